// File: doc/BRIEF.md
# Transmit Descriptor Ring Poller

This engine serves the transmit side of a network controller. It walks a circular ring of four-word descriptors in shared memory. Each descriptor carries a buffer address, a negated length, a flag byte and a status word. The ownership bit in the flag byte passes each entry between host software and the engine. Whenever it is prompted, the engine reads the flag byte of the entry at its current index and stops at the first entry the host owns. For each entry the engine owns, it hands the buffer address and byte count to a separate frame datapath and waits for that datapath's result. It then writes the result back, status word first and flag byte second, and moves on to the next entry.

There are two ways to prompt the engine. A demand pulse starts a scan at once. While the transmitter is enabled and idle, an internal timer also starts a scan every `POLL_CYCLES` cycles. The start and stop inputs enable and disable the transmitter. Stop also returns the ring index to entry 0 and abandons any descriptor access in progress. If the datapath reports a fatal result (underflow or missing end of packet), the engine disables itself after writing that result back.

Top module: `tx_ring_poller`

## Requirements
- R1: After reset `txOn`, `memReq`, `memWe`, `txStart` and `frameDone` are all 0.
- R2: A `startReq` pulse sets `txOn`. A `stopReq` pulse clears `txOn`, drops `memReq` from the next cycle and rewinds the ring index to entry 0, with no write-back of an abandoned entry. Stop wins over a simultaneous start.
- R3: A `demand` pulse while `txOn` is 1 starts a read of the current entry's flag word without waiting for the timer. A demand while `txOn` is 0 causes no memory access.
- R4: While `txOn` is 1 and the engine is idle, it reads the current flag word again every `POLL_CYCLES` (default 1600) cycles, so an entry handed over without a demand is still sent.
- R5: Descriptor i lies at word address B + 4·i, where B = {`initWord`[7:0], `ringLo`}. Word 0 holds buffer address bits 15:0. Word 1 holds the flag byte in bits 15:8 and buffer address bits 23:16 in bits 7:0. Word 2 holds the length and word 3 the status.
- R6: If bit 15 of flag word (ownership, 1 = engine owns) is 0, the engine transmits nothing and goes idle at the same index.
- R7: For an owned entry, `txStart` pulses for one cycle. `txBufAddr` is {high byte, low word}. `txByteCount` is the low 12 bits of the two's-complement negation of the length word.
- R8: The status word written back equals `txStatus` with bit 13 forced to 0. It is written before the flag word.
- R9: The flag byte written back has bit 7 = 0 and bit 5 = 0. Bit 6 is the OR of status bits 10, 11, 12, 14 and 15. Bits 4:2 are `txRetry` ({several retries, one retry, deferred}). Bits 1:0 keep their read value. The high address byte is unchanged.
- R10: One cycle after the flag write is acknowledged, `frameDone` pulses for one cycle. The index advances modulo 2^`initWord`[15:13], and the next entry is read at once.
- R11: If status bit 14 (underflow) or bit 15 (buffer error) is set, `txOn` is cleared once the flag write completes. No further scan happens until `startReq`.
- R12: `memReq` stays high with a stable `memAddr` until `memAck`, unless `stopReq` intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Enable transmitter pulse |
| stopReq | input | 1 | Disable, rewind and abort pulse |
| demand | input | 1 | Scan-now pulse |
| ringLo | input | 16 | Ring base word address, low 16 bits |
| initWord | input | 16 | Bits 15:13 log2 of entry count, bits 7:0 ring base high bits |
| memReq | output | 1 | Descriptor memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | ADDR_W | Descriptor word address |
| memWdata | output | 16 | Write data |
| memAck | input | 1 | Access complete, read data valid |
| memRdata | input | 16 | Read data |
| txStart | output | 1 | Launch frame on datapath |
| txBufAddr | output | 24 | Frame buffer address |
| txByteCount | output | 12 | Frame byte count |
| txDone | input | 1 | Datapath result valid |
| txStatus | input | 16 | Result status word |
| txRetry | input | 3 | {several retries, one retry, deferred} |
| frameDone | output | 1 | Frame completed event |
| txOn | output | 1 | Transmitter enabled |

## Verification
Every cycle, the assertions check several timing rules. `txStart` and `frameDone` are single-cycle pulses, and `frameDone` follows an acknowledged write. Every flag write comes straight after the status write of the same entry and clears ownership. Requests hold until acknowledged, stop takes effect on the next cycle, and `txOn` falls only after a stop or a completed frame. Other behaviour depends on what is in the memory model, so only the bench scenarios can show it. This covers the negated-length arithmetic, the error-summary and retry bits written back, the wrap of the index at the ring size, the walk across consecutive owned entries, the poll interval and the rewind to entry 0 after stop.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_FLAG,
    ST_RD_BASE,
    ST_RD_LEN,
    ST_LAUNCH,
    ST_WAIT,
    ST_WR_STAT,
    ST_WR_FLAG
  } ringState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic       pollStart;
    logic       ldFlag;
    logic       ldBase;
    logic       ldLen;
    logic       ldResult;
    logic       advance;
    logic       rewind;
    logic       timerRun;
    logic [1:0] wordSel;
  } ringStrobe_t;

  localparam logic [1:0] OFS_BASE = 2'd0;
  localparam logic [1:0] OFS_FLAG = 2'd1;
  localparam logic [1:0] OFS_LEN  = 2'd2;
  localparam logic [1:0] OFS_STAT = 2'd3;

endpackage

// File: rtl/tx_ring_ctrl.sv
module tx_ring_ctrl
  import tx_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        stopReq,
  input  logic        memAck,
  input  logic        txDone,
  input  logic        pollGo,
  input  logic        ownBit,
  input  logic        hardErr,
  output ringStrobe_t strobe,
  output logic        memReq,
  output logic        memWe,
  output logic        txStart,
  output logic        frameDone,
  output logic        txOn
);

  ringState_t state, nextState;
  logic inMem, inWrite, flagAck;

  assign inMem   = (state == ST_RD_FLAG) || (state == ST_RD_BASE) || (state == ST_RD_LEN) ||
                   (state == ST_WR_STAT) || (state == ST_WR_FLAG);
  assign inWrite = (state == ST_WR_STAT) || (state == ST_WR_FLAG);
  assign memReq  = inMem && !stopReq;
  assign memWe   = inWrite && !stopReq;
  assign txStart = (state == ST_LAUNCH) && !stopReq;
  assign flagAck = (state == ST_WR_FLAG) && memAck && !stopReq;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        strobe.timerRun = txOn;
        if (txOn && pollGo) begin
          nextState        = ST_RD_FLAG;
          strobe.pollStart = 1'b1;
        end
      end
      ST_RD_FLAG: begin
        strobe.wordSel = OFS_FLAG;
        if (memAck) begin
          strobe.ldFlag = 1'b1;
          nextState     = ownBit ? ST_RD_BASE : ST_IDLE;
        end
      end
      ST_RD_BASE: begin
        strobe.wordSel = OFS_BASE;
        if (memAck) begin
          strobe.ldBase = 1'b1;
          nextState     = ST_RD_LEN;
        end
      end
      ST_RD_LEN: begin
        strobe.wordSel = OFS_LEN;
        if (memAck) begin
          strobe.ldLen = 1'b1;
          nextState    = ST_LAUNCH;
        end
      end
      ST_LAUNCH: nextState = ST_WAIT;
      ST_WAIT: begin
        if (txDone) begin
          strobe.ldResult = 1'b1;
          nextState       = ST_WR_STAT;
        end
      end
      ST_WR_STAT: begin
        strobe.wordSel = OFS_STAT;
        if (memAck) nextState = ST_WR_FLAG;
      end
      ST_WR_FLAG: begin
        strobe.wordSel = OFS_FLAG;
        if (memAck) begin
          strobe.advance = 1'b1;
          if (hardErr) nextState = ST_IDLE;
          else begin
            nextState        = ST_RD_FLAG;
            strobe.pollStart = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
    if (stopReq) begin
      strobe        = '0;
      strobe.rewind = 1'b1;
      nextState     = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      frameDone <= 1'b0;
      txOn      <= 1'b0;
    end else begin
      state     <= nextState;
      frameDone <= flagAck;
      if (stopReq)                txOn <= 1'b0;
      else if (flagAck && hardErr) txOn <= 1'b0;
      else if (startReq)           txOn <= 1'b1;
    end
  end

endmodule

// File: rtl/tx_ring_dpath.sv
module tx_ring_dpath
  import tx_ring_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int LOG_W       = 3,
  parameter int POLL_CYCLES = 1600
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       strobe,
  input  logic              demand,
  input  logic              txOn,
  input  logic [15:0]       ringLo,
  input  logic [15:0]       initWord,
  input  logic [15:0]       memRdata,
  input  logic [15:0]       txStatus,
  input  logic [2:0]        txRetry,
  output logic              pollGo,
  output logic              ownBit,
  output logic              hardErr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWdata,
  output logic [23:0]       txBufAddr,
  output logic [11:0]       txByteCount
);

  localparam int IDX_W = (1 << LOG_W) - 1;
  localparam int CNT_W = $clog2(POLL_CYCLES);
  localparam logic [15:0] RSVD_MASK = 16'hDFFF;

  logic [IDX_W-1:0]  idx, ringMask;
  logic [CNT_W-1:0]  pollCnt;
  logic              pollDue, demandPend, errAny;
  logic [7:0]        flagReg, hiBase, newFlag;
  logic [15:0]       baseLo, lenReg, statReg, negLen;
  logic [2:0]        retryReg;
  logic [ADDR_W-1:0] ringBase;
  logic              unusedBits;

  assign unusedBits = ^{initWord[12:8], flagReg[7:2]};

  assign ringMask = (IDX_W'(1) << initWord[15 -: LOG_W]) - IDX_W'(1);
  assign ringBase = ADDR_W'({initWord[7:0], ringLo});
  assign memAddr  = ringBase + ADDR_W'({idx, 2'b00}) + ADDR_W'(strobe.wordSel);

  assign pollDue = (pollCnt == CNT_W'(POLL_CYCLES - 1));
  assign pollGo  = pollDue || demand || demandPend;
  assign ownBit  = memRdata[15];

  assign errAny  = statReg[15] | statReg[14] | statReg[12] | statReg[11] | statReg[10];
  assign hardErr = statReg[15] | statReg[14];
  assign newFlag = {1'b0, errAny, 1'b0, retryReg, flagReg[1:0]};
  assign memWdata = (strobe.wordSel == OFS_STAT) ? (statReg & RSVD_MASK) : {newFlag, hiBase};

  assign negLen      = ~lenReg + 16'd1;
  assign txByteCount = negLen[11:0];
  assign txBufAddr   = {hiBase, baseLo};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx        <= '0;
      pollCnt    <= '0;
      demandPend <= 1'b0;
      flagReg    <= '0;
      hiBase     <= '0;
      baseLo     <= '0;
      lenReg     <= '0;
      statReg    <= '0;
      retryReg   <= '0;
    end else begin
      if (strobe.rewind)       idx <= '0;
      else if (strobe.advance) idx <= (idx + IDX_W'(1)) & ringMask;

      pollCnt <= strobe.timerRun ? pollCnt + CNT_W'(1) : '0;

      if (strobe.rewind || strobe.pollStart || !txOn) demandPend <= 1'b0;
      else if (demand)                                demandPend <= 1'b1;

      if (strobe.ldFlag) begin
        flagReg <= memRdata[15:8];
        hiBase  <= memRdata[7:0];
      end
      if (strobe.ldBase) baseLo <= memRdata;
      if (strobe.ldLen)  lenReg <= memRdata;
      if (strobe.ldResult) begin
        statReg  <= txStatus;
        retryReg <= txRetry;
      end
    end
  end

endmodule

// File: rtl/tx_ring_poller.sv
module tx_ring_poller
  import tx_ring_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int LOG_W       = 3,
  parameter int POLL_CYCLES = 1600
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              stopReq,
  input  logic              demand,
  input  logic [15:0]       ringLo,
  input  logic [15:0]       initWord,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWdata,
  input  logic              memAck,
  input  logic [15:0]       memRdata,
  output logic              txStart,
  output logic [23:0]       txBufAddr,
  output logic [11:0]       txByteCount,
  input  logic              txDone,
  input  logic [15:0]       txStatus,
  input  logic [2:0]        txRetry,
  output logic              frameDone,
  output logic              txOn
);

  ringStrobe_t strobe;
  logic pollGo, ownBit, hardErr;

  tx_ring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .memAck(memAck), .txDone(txDone), .pollGo(pollGo), .ownBit(ownBit),
    .hardErr(hardErr), .strobe(strobe), .memReq(memReq), .memWe(memWe),
    .txStart(txStart), .frameDone(frameDone), .txOn(txOn)
  );

  tx_ring_dpath #(.ADDR_W(ADDR_W), .LOG_W(LOG_W), .POLL_CYCLES(POLL_CYCLES)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .demand(demand), .txOn(txOn),
    .ringLo(ringLo), .initWord(initWord), .memRdata(memRdata),
    .txStatus(txStatus), .txRetry(txRetry), .pollGo(pollGo), .ownBit(ownBit),
    .hardErr(hardErr), .memAddr(memAddr), .memWdata(memWdata),
    .txBufAddr(txBufAddr), .txByteCount(txByteCount)
  );

endmodule

// File: rtl/tx_ring_poller_chk.sv
module tx_ring_poller_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              stopReq,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic              wrOwn,
  input logic              txStart,
  input logic              frameDone,
  input logic              txOn
);

  logic              expectFlag;
  logic [ADDR_W-1:0] statAddr;
  logic              wrAck;

  assign wrAck = memReq && memWe && memAck;

  always_ff @(posedge clk) begin
    if (!rstN || stopReq) begin
      expectFlag <= 1'b0;
      statAddr   <= '0;
    end else if (wrAck) begin
      expectFlag <= !expectFlag;
      statAddr   <= memAddr;
    end
  end

  assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart);

  assert_frame_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  assert_frame_after_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(wrAck));

  assert_stop_quiets_R2: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> (!memReq && !txOn));

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !stopReq) |=> (stopReq || (memReq && $stable(memAddr))));

  assert_we_needs_req_R12: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq);

  assert_status_first_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrAck && expectFlag) |-> (memAddr == statAddr - ADDR_W'(2)));

  assert_own_released_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrAck && expectFlag) |-> !wrOwn);

  assert_txoff_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txOn) |-> ($past(stopReq) || frameDone));

endmodule

bind tx_ring_poller tx_ring_poller_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .stopReq(stopReq), .memReq(memReq), .memWe(memWe),
  .memAck(memAck), .memAddr(memAddr), .wrOwn(memWdata[15]), .txStart(txStart),
  .frameDone(frameDone), .txOn(txOn)
);

// File: tb/test_tx_ring_poller.sv
`timescale 1ns/1ps
module test_tx_ring_poller;

  localparam int AW = 24;
  localparam logic [7:0] RB = 8'd16;   // ring base word address

  // {length word, status from datapath, retry bits}
  localparam logic [34:0] VECS [6] = '{
    {16'hFFC4, 16'h0000, 3'b000},
    {16'hFA00, 16'h0000, 3'b010},
    {16'hFFFF, 16'h0C00, 3'b100},
    {16'hF000, 16'h2005, 3'b001},
    {16'hF800, 16'h1000, 3'b000},
    {16'hFFC3, 16'h03FF, 3'b111}
  };

  logic clk = 1'b0, rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic startReq = 0, stopReq = 0, demand = 0;
  logic [15:0] ringLo = {8'h00, RB}, initWord = 16'h4000; // 4 entries
  logic memReq, memWe, memAck, txStart, frameDone, txOn, txDone;
  logic [AW-1:0] memAddr;
  logic [15:0] memWdata, memRdata, txStatus;
  logic [23:0] txBufAddr;
  logic [11:0] txByteCount;
  logic [2:0]  txRetry;

  logic [15:0] nextStatus = 0;
  logic [2:0]  nextRetry = 0;
  int          dpDelay = 5;
  assign txStatus = nextStatus;
  assign txRetry  = nextRetry;

  tx_ring_poller #(.ADDR_W(AW)) i_tx_ring_poller (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq), .demand(demand),
    .ringLo(ringLo), .initWord(initWord), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata),
    .txStart(txStart), .txBufAddr(txBufAddr), .txByteCount(txByteCount),
    .txDone(txDone), .txStatus(txStatus), .txRetry(txRetry),
    .frameDone(frameDone), .txOn(txOn)
  );

  // shared memory model with host write port
  logic [15:0] mem [256];
  logic ackR = 0;
  logic [15:0] rdR = 0;
  logic hostWe = 0;
  logic [7:0] hostAddr = 0;
  logic [15:0] hostData = 0;
  logic [7:0] lastRdAddr = 0, lastWrAddr = 0;
  int reqCycles = 0, frameCnt = 0, startCnt = 0;
  assign memAck = ackR;
  assign memRdata = rdR;

  always @(posedge clk) begin
    if (!rstN) begin
      ackR <= 0;
      for (int k = 0; k < 256; k++) mem[k] <= 16'h0;
    end else begin
      if (hostWe) mem[hostAddr] <= hostData;
      if (memReq && !ackR) begin
        ackR <= 1;
        if (memWe) begin
          mem[memAddr[7:0]] <= memWdata;
          lastWrAddr <= memAddr[7:0];
        end else begin
          rdR <= mem[memAddr[7:0]];
          lastRdAddr <= memAddr[7:0];
        end
      end else ackR <= 0;
      if (memReq) reqCycles <= reqCycles + 1;
      if (frameDone) frameCnt <= frameCnt + 1;
    end
  end

  // frame datapath model
  logic dpBusy = 0;
  int dpCnt = 0;
  logic [23:0] capAddr = 0;
  logic [11:0] capCount = 0;
  initial txDone = 0;
  always @(posedge clk) begin
    txDone <= 0;
    if (txStart) begin
      dpBusy <= 1; dpCnt <= dpDelay; capAddr <= txBufAddr; capCount <= txByteCount;
      startCnt <= startCnt + 1;
    end else if (dpBusy) begin
      if (dpCnt == 0) begin txDone <= 1; dpBusy <= 0; end
      else dpCnt <= dpCnt - 1;
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setWord(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); hostAddr = a; hostData = d; hostWe = 1;
    @(negedge clk); hostWe = 0;
  endtask

  task automatic setDesc(input int idx, input logic [15:0] lo, input logic [7:0] flag,
                         input logic [7:0] hi, input logic [15:0] len);
    logic [7:0] b;
    b = RB + 8'(idx * 4);
    setWord(b, lo);
    setWord(b + 8'd2, len);
    setWord(b + 8'd3, 16'h0);
    setWord(b + 8'd1, {flag, hi});
  endtask

  task automatic pulseDemand();
    @(negedge clk); demand = 1; @(negedge clk); demand = 0;
  endtask
  task automatic pulseStart();
    @(negedge clk); startReq = 1; @(negedge clk); startReq = 0;
  endtask

  task automatic waitFrames(input int target, input int limit);
    for (int n = 0; n < limit && frameCnt < target; n++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    int f0, s0, r0, gap, idx;
    logic [15:0] len, st, wrStat;
    logic [2:0] rt;
    logic [1:0] lowBits;
    logic [7:0] b, hi, expFlag;
    logic err;

    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 txOn", txOn, 0);
    chk("R1 memReq", memReq, 0);
    chk("R1 memWe", memWe, 0);
    chk("R1 txStart/frameDone", {txStart, frameDone}, 0);
    @(negedge clk); rstN = 1;
    repeat (3) @(negedge clk);

    // R3 demand ignored while off
    r0 = reqCycles;
    pulseDemand();
    repeat (30) @(negedge clk);
    chk("R3 demand while off", reqCycles - r0, 0);

    // R2 start enables
    pulseStart();
    chk("R2 txOn after start", txOn, 1);

    // R3/R6 demand reads entry 0 flag, host-owned -> no transmit
    r0 = reqCycles; s0 = startCnt;
    pulseDemand();
    repeat (30) @(negedge clk);
    chk("R3 demand polls", reqCycles > r0, 1);
    chk("R5 flag word addr", lastRdAddr, RB + 8'd1);
    chk("R6 host-owned skipped", startCnt - s0, 0);

    // table-driven frames, wraps after 4 entries (R7 R8 R9 R10)
    for (int i = 0; i < 6; i++) begin
      {len, st, rt} = VECS[i];
      idx = i % 4;
      b = RB + 8'(idx * 4);
      hi = 8'h20 + 8'(i);
      lowBits = i[0] ? 2'b01 : 2'b11;
      nextStatus = st; nextRetry = rt;
      setDesc(idx, 16'h1000 + 16'(i), {6'b100000, lowBits}, hi, len);
      f0 = frameCnt; s0 = startCnt;
      pulseDemand();
      waitFrames(f0 + 1, 300);
      repeat (20) @(negedge clk);
      err = |(st & 16'hDC00);
      expFlag = {1'b0, err, 1'b0, rt, lowBits};
      wrStat = st & 16'hDFFF;
      chk($sformatf("R7 byte count v%0d", i), capCount, 12'(16'h0 - len));
      chk($sformatf("R7 buffer addr v%0d", i), capAddr, {hi, 16'h1000 + 16'(i)});
      chk($sformatf("R8 status word v%0d", i), mem[b + 8'd3], wrStat);
      chk($sformatf("R9 flag word v%0d", i), mem[b + 8'd1], {expFlag, hi});
      chk($sformatf("R10 one frame v%0d", i), {8'(frameCnt - f0), 8'(startCnt - s0)}, 16'h0101);
      chk($sformatf("R10 index wrap v%0d", i), lastWrAddr, b + 8'd1);
    end

    // R10 walk across two owned entries with one demand (index now 2)
    nextStatus = 0; nextRetry = 0;
    setDesc(2, 16'h0100, 8'h83, 8'h00, 16'hFFC4);
    setDesc(3, 16'h0200, 8'h83, 8'h00, 16'hFFC4);
    f0 = frameCnt;
    pulseDemand();
    waitFrames(f0 + 2, 400);
    repeat (20) @(negedge clk);
    chk("R10 walk two entries", frameCnt - f0, 2);
    chk("R10 walk stops at host entry", lastRdAddr, RB + 8'd1);

    // R4 poll interval (idle at index 0)
    gap = 0;
    for (int n = 0; n < 2500 && !memReq; n++) @(negedge clk);
    for (int n = 0; n < 20 && memReq; n++) @(negedge clk);
    for (int n = 0; n < 2500 && !memReq; n++) begin @(negedge clk); gap++; end
    chk("R4 poll gap near 1600", (gap >= 1598 && gap <= 1602), 1);
    f0 = frameCnt;
    setDesc(0, 16'h0300, 8'h83, 8'h00, 16'hFFC4);
    waitFrames(f0 + 1, 2000);
    chk("R4 timer sends without demand", frameCnt - f0, 1);

    // R11 underflow disables transmitter (index now 1)
    repeat (20) @(negedge clk);
    nextStatus = 16'h4000;
    setDesc(1, 16'h0400, 8'h83, 8'h00, 16'hFFC4);
    f0 = frameCnt;
    pulseDemand();
    waitFrames(f0 + 1, 300);
    chk("R11 txOn cleared", txOn, 0);
    chk("R9 underflow flag", mem[RB + 8'd5], 16'h4300);
    nextStatus = 0;
    setDesc(2, 16'h0500, 8'h83, 8'h00, 16'hFFC4);
    s0 = startCnt; r0 = reqCycles;
    pulseDemand();
    repeat (50) @(negedge clk);
    chk("R11 no scan while off", {8'(startCnt - s0), 8'(reqCycles - r0)}, 0);
    pulseStart();
    f0 = frameCnt;
    pulseDemand();
    waitFrames(f0 + 1, 300);
    repeat (20) @(negedge clk);
    chk("R11 resumes after start", frameCnt - f0, 1);

    // R2 stop aborts mid-frame and rewinds (index now 3)
    dpDelay = 100;
    setDesc(3, 16'h0600, 8'h83, 8'h00, 16'hFFC4);
    s0 = startCnt; f0 = frameCnt;
    pulseDemand();
    for (int n = 0; n < 100 && startCnt == s0; n++) @(negedge clk);
    repeat (10) @(negedge clk);
    stopReq = 1; @(negedge clk); stopReq = 0;
    chk("R2 stop drops req/txOn", {memReq, txOn}, 0);
    repeat (150) @(negedge clk);
    chk("R2 abandoned entry not written", {8'(frameCnt - f0), 7'd0, mem[RB + 8'd13][15]}, 16'h0001);
    dpDelay = 5;
    pulseStart();
    pulseDemand();
    repeat (30) @(negedge clk);
    chk("R2 rewind to entry 0", lastRdAddr, RB + 8'd1);

    // R2 stop wins over simultaneous start
    @(negedge clk); startReq = 1; stopReq = 1;
    @(negedge clk); startReq = 0; stopReq = 0;
    chk("R2 stop beats start", txOn, 0);

    finishRun();
  end

endmodule